// File: doc/BRIEF.md
# Seek Busy and Settle Timer

This block decides when the head positioner of a disk drive is busy and when a seek is complete. A seek begins when the address-difference input reports that the demanded cylinder is not the current cylinder. That sets the busy state and empties a settle timer. When the difference is gone and the head reports it is on track, position mode is true. The settle timer then fills one stage per divided-clock tick. The settle delay is therefore the stage count times the tick period.

When the last stage fills, the block emits a one-cycle end-busy pulse. The pulse clears the busy state and any restore operation in progress. A restore request sets the restore status and a hold-busy flag, and it restarts the settle timer. This keeps the host seeing busy until the head has settled on its restore target.

The busy indication reaches the host only while ready is high. While ready is low, all three status flip-flops are forced clear. The interface has no data stream, so every pin is a plain level or a single-cycle strobe.

Top module: `seek_settle_ctrl`

## Requirements
- R1: After reset, `busy_o`, `end_busy_o` and `restore_o` are all 0.
- R2: With `ready_i` high, a cycle with `addr_diff_i` high makes `busy_o` 1 from the next clock edge onward.
- R3: Any cycle where position mode is false (`addr_diff_i` high or `on_track_i` low) empties the settle timer. The count then restarts, and a full `SETTLE_STAGES` ticks are needed again.
- R4: The settle timer advances only on cycles with `tick_i` high while position mode is true. Any number of cycles without a tick leaves `end_busy_o` at 0 and `busy_o` at 1.
- R5: After position mode becomes true, `end_busy_o` stays 0 through the first `SETTLE_STAGES-1` ticks. It is 1 for exactly one cycle, the cycle after the clock edge that takes the tick numbered `SETTLE_STAGES` (default 8).
- R6: The clock edge that ends the `end_busy_o` cycle clears the busy and restore state, so `busy_o` and `restore_o` read 0 after it.
- R7: `busy_o` is 0 in any cycle with `ready_i` low. A clock edge with `ready_i` low clears the busy, hold-busy and restore flip-flops, so `busy_o` stays 0 after ready returns. This holds until a new seek or restore starts.
- R8: With `ready_i` high, a `restore_start_i` strobe sets `restore_o` and `busy_o` from the next edge and empties the settle timer. The following completed settle clears both.
- R9: A `restore_start_i` strobe while `ready_i` is low is ignored: `restore_o` and `busy_o` remain 0 once ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_diff_i | input | 1 | Demand cylinder differs from current cylinder |
| on_track_i | input | 1 | Head within a quarter track of the track centre |
| tick_i | input | 1 | Single-cycle enable from the settle clock divider |
| ready_i | input | 1 | Drive ready; gates and releases busy state |
| restore_start_i | input | 1 | Single-cycle request to begin a restore |
| busy_o | output | 1 | Positioner busy, to the host |
| end_busy_o | output | 1 | One-cycle pulse when the settle delay completes |
| restore_o | output | 1 | Restore operation in progress |

## Verification
The assertions assume that every input is synchronous to `clk` and that `tick_i` is a one-cycle enable rather than a level. They also assume that position mode is derived from the two input levels and is never presented as a glitch within a cycle. The bench drives all inputs on the falling edge and raises `tick_i` for exactly one rising edge at a time. It samples outputs on the falling edge, or one nanosecond after a falling-edge change of `ready_i` to observe the combinational gating.

// File: rtl/seek_pkg.sv
package seek_pkg;
  localparam int unsigned SETTLE_STAGES_DEF = 8;

  typedef struct packed {
    logic busy;
    logic hold;
    logic restore;
  } seek_flags_t;
endpackage

// File: rtl/seek_settle_delay.sv
module seek_settle_delay #(
  parameter int unsigned DEPTH = seek_pkg::SETTLE_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic shift_i,
  output logic full_o,
  output logic end_pulse_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] stg;
  logic             full_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic feed;
      logic q;
      if (i == 0) begin : g_head
        assign feed = 1'b1;
      end else begin : g_link
        assign feed = stg[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= 1'b0;
        else if (clr_i)   q <= 1'b0;
        else if (shift_i) q <= feed;
      end
      assign stg[i] = q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= stg[LAST];
  end

  assign full_o      = stg[LAST];
  assign end_pulse_o = stg[LAST] & ~full_q;

  // R3
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stg == '0));

  // R4
  thermometer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stg & (stg + DEPTH'(1))) == '0));

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i && !stg[LAST]) |=> ($countones(stg) == $past($countones(stg)) + 1));

  // R4
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !clr_i) |=> $stable(stg));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse_o |=> !end_pulse_o);
endmodule

// File: rtl/seek_busy_flops.sv
module seek_busy_flops
  import seek_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ready_i,
  input  logic        seek_go_i,
  input  logic        restore_go_i,
  input  logic        end_i,
  output seek_flags_t flags_o
);
  seek_flags_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (!ready_i) begin
      st <= '0;
    end else begin
      if (seek_go_i)  st.busy <= 1'b1;
      else if (end_i) st.busy <= 1'b0;

      if (seek_go_i)         st.hold <= 1'b0;
      else if (restore_go_i) st.hold <= 1'b1;
      else if (end_i)        st.hold <= 1'b0;

      if (restore_go_i) st.restore <= 1'b1;
      else if (end_i)   st.restore <= 1'b0;
    end
  end

  assign flags_o = st;

  // R2
  seek_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && seek_go_i) |=> flags_o.busy);

  // R7
  ready_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> (flags_o == '0));

  // R8
  restore_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && restore_go_i) |=> flags_o.restore);

  // R6
  end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && end_i && !seek_go_i && !restore_go_i) |=> (flags_o == '0));
endmodule

// File: rtl/seek_settle_ctrl.sv
module seek_settle_ctrl
  import seek_pkg::*;
#(
  parameter int unsigned SETTLE_STAGES = SETTLE_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_diff_i,
  input  logic on_track_i,
  input  logic tick_i,
  input  logic ready_i,
  input  logic restore_start_i,
  output logic busy_o,
  output logic end_busy_o,
  output logic restore_o
);
  logic        pos_mode;
  logic        restore_go;
  logic        settle_clr;
  logic        settle_full;
  logic        settle_end;
  seek_flags_t flags;

  assign pos_mode   = on_track_i & ~addr_diff_i;
  assign restore_go = restore_start_i & ready_i;
  assign settle_clr = ~pos_mode | restore_go;

  seek_settle_delay #(.DEPTH(SETTLE_STAGES)) u_settle (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (settle_clr),
    .shift_i     (tick_i),
    .full_o      (settle_full),
    .end_pulse_o (settle_end)
  );

  seek_busy_flops u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready_i      (ready_i),
    .seek_go_i    (addr_diff_i),
    .restore_go_i (restore_go),
    .end_i        (settle_end),
    .flags_o      (flags)
  );

  assign busy_o     = ready_i & (flags.busy | flags.hold);
  assign end_busy_o = settle_end;
  assign restore_o  = flags.restore;

  // R3
  no_end_after_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_diff_i |=> !end_busy_o);

  // R8
  restore_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_go |=> (!settle_full && busy_o | !ready_i));
endmodule

// File: tb/seek_settle_ctrl_tb.sv
`timescale 1ns/1ps
module seek_settle_ctrl_tb;
  localparam int unsigned DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_diff = 1'b0;
  logic on_track = 1'b0;
  logic tick = 1'b0;
  logic ready = 1'b1;
  logic restore_start = 1'b0;
  logic busy, end_busy, restore;

  int nvec = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  seek_settle_ctrl #(.SETTLE_STAGES(DEPTH)) u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_diff_i     (addr_diff),
    .on_track_i      (on_track),
    .tick_i          (tick),
    .ready_i         (ready),
    .restore_start_i (restore_start),
    .busy_o          (busy),
    .end_busy_o      (end_busy),
    .restore_o       (restore)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic tick1();
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic begin_seek();
    addr_diff = 1'b1;
    on_track  = 1'b0;
    idle(1);
    chk("R2 busy after difference", busy, 1'b1);
    addr_diff = 1'b0;
    on_track  = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 busy at reset", busy, 1'b0);
    chk("R1 end at reset", end_busy, 1'b0);
    chk("R1 restore at reset", restore, 1'b0);
  endtask

  task automatic t_basic();
    begin_seek();
    for (int i = 0; i < DEPTH - 1; i++) begin
      tick1();
      chk("R5 no end before last tick", end_busy, 1'b0);
      chk("R2 busy held while settling", busy, 1'b1);
    end
    tick1();
    chk("R5 end pulse on last tick", end_busy, 1'b1);
    chk("R6 busy still high during pulse", busy, 1'b1);
    idle(1);
    chk("R5 pulse lasts one cycle", end_busy, 1'b0);
    chk("R6 busy cleared by end", busy, 1'b0);
  endtask

  task automatic t_no_tick();
    begin_seek();
    for (int i = 0; i < 20; i++) begin
      idle(1);
      chk("R4 no end without ticks", end_busy, 1'b0);
    end
    chk("R4 busy held without ticks", busy, 1'b1);
    for (int i = 0; i < DEPTH; i++) tick1();
    chk("R4 end after full ticks", end_busy, 1'b1);
    idle(1);
    chk("R6 busy cleared", busy, 1'b0);
  endtask

  task automatic t_restart();
    begin_seek();
    for (int i = 0; i < 3; i++) tick1();
    on_track = 1'b0;
    idle(1);
    on_track = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) begin
      tick1();
      chk("R3 count restarted after off track", end_busy, 1'b0);
    end
    tick1();
    chk("R3 end after full recount", end_busy, 1'b1);
    idle(1);
    begin_seek();
    for (int i = 0; i < 5; i++) tick1();
    addr_diff = 1'b1;
    tick1();
    chk("R3 new difference keeps busy", busy, 1'b1);
    chk("R3 no end during difference", end_busy, 1'b0);
    addr_diff = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      tick1();
      chk("R3 count restarted after difference", end_busy, 1'b0);
    end
    tick1();
    chk("R3 end after recount", end_busy, 1'b1);
    idle(1);
    chk("R6 busy cleared after recount", busy, 1'b0);
  endtask

  task automatic t_ready();
    begin_seek();
    tick1();
    tick1();
    ready = 1'b0;
    #1;
    chk("R7 busy gated by ready", busy, 1'b0);
    @(negedge clk);
    ready = 1'b1;
    #1;
    chk("R7 busy state released", busy, 1'b0);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      tick1();
      chk("R7 busy stays clear", busy, 1'b0);
    end
    idle(1);
  endtask

  task automatic t_restore();
    restore_start = 1'b1;
    idle(1);
    restore_start = 1'b0;
    chk("R8 restore set", restore, 1'b1);
    chk("R8 busy during restore", busy, 1'b1);
    chk("R8 no end at restore start", end_busy, 1'b0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      tick1();
      chk("R8 restore held while settling", restore, 1'b1);
      chk("R8 settle restarted", end_busy, 1'b0);
    end
    tick1();
    chk("R8 end after restore settle", end_busy, 1'b1);
    idle(1);
    chk("R8 restore cleared", restore, 1'b0);
    chk("R8 busy cleared", busy, 1'b0);
  endtask

  task automatic t_restore_not_ready();
    ready = 1'b0;
    restore_start = 1'b1;
    idle(1);
    restore_start = 1'b0;
    ready = 1'b1;
    #1;
    chk("R9 restore ignored", restore, 1'b0);
    chk("R9 busy not raised", busy, 1'b0);
    @(negedge clk);
    idle(1);
    chk("R9 restore still clear", restore, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_no_tick();
    t_restart();
    t_ready();
    t_restore();
    t_restore_not_ready();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule